// File: doc/BRIEF.md
# In-Band Repeating Code Detector

This block watches a received T1 payload bit stream for two programmable repeating codes, an activate code and a deactivate code. Both codes share one programmable period of 4, 5, 6 or 7 bits. A code with a shorter period, such as a 3-bit code, is programmed as a longer period that holds whole copies of it. The block needs no extra logic for that case.

A detector declares its code present after a programmable number of consecutive valid bits in which the most recent N received bits form some rotation of the code. The match can start at any bit of the code. The present flag drops after the same number of consecutive valid bits that do not match. Each rising edge of a present flag sets a sticky interrupt status bit, which software clears by writing one. An enable mask combines the interrupt status bits into a single interrupt request. The block only reports these events; the processor that receives the interrupt decides whether to act on it. When the line-rate select indicates E1, the block holds all of its state cleared.

Top module: `ibcode_det_top`

## Requirements
- R1: After reset, `code_present`, `irq_status` and `irq_req` are all zero.
- R2: `len_sel` sets the code period N as 4 + `len_sel` (00 gives 4, 11 gives 7). Only bits N-1..0 of each pattern input are used, and bit N-1 is the first bit of the code in time.
- R3: A detector's match condition holds on a valid bit when at least N valid bits have arrived since reset or since entry to T1 mode, and the last N of them, oldest first, form some rotation of the code. The detector sets `code_present` on the valid bit that completes `hit_count` consecutive matching valid bits. The flag is visible one clock after that bit is sampled.
- R4: A valid bit without a match restarts the consecutive-match count, so an interrupted run shorter than `hit_count` never sets `code_present`.
- R5: While a code is present, `hit_count` consecutive non-matching valid bits clear `code_present`. A matching bit restarts that count.
- R6: The two detectors (index 0 activate, index 1 deactivate) run independently on the same stream, and both can be present at once.
- R7: Each rising edge of `code_present[i]` sets `irq_status[i]` one clock later. The bit stays set until a cycle with `irq_clr[i]` high clears it (write-one-to-clear).
- R8: `irq_req` is high in the same cycle that any bit of `irq_status & irq_en` is high, and low otherwise.
- R9: Cycles with `bit_vld` low leave detector state unchanged, whatever the value on `bit_in`.
- R10: While `t1_mode` is 0 (E1), all state clears on each clock. All outputs stay zero and all bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Received payload bit |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| t1_mode | input | 1 | 1 = T1 (active), 0 = E1 (held idle) |
| len_sel | input | 2 | Code period select, N = 4 + len_sel |
| pat_act | input | 7 | Activate code, low N bits used |
| pat_deact | input | 7 | Deactivate code, low N bits used |
| hit_count | input | 12 | Consecutive bits needed to set or clear presence |
| irq_en | input | 2 | Interrupt enable per code |
| irq_clr | input | 2 | Write-one-to-clear pulse per code |
| code_present | output | 2 | Code present status, [0] activate, [1] deactivate |
| irq_status | output | 2 | Sticky interrupt status per code |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a run that almost qualifies: a code stream broken by a single wrong bit, where the mismatch stays in the N-bit window for several bits. Only the exact count of surviving matches decides whether presence appears. The bench drives that case, and also a start at an arbitrary bit of the code and two codes that are rotations of each other. It predicts every bit with its own rotation model, which walks each phase explicitly. Qualifier gaps carrying random data, a 3-bit code programmed as a 6-bit period, and a spell in E1 mode cover the other corners.

// File: rtl/ibcode_pkg.sv
`timescale 1ns/1ps
package ibcode_pkg;
    localparam int MIN_LEN   = 4;
    localparam int MAX_LEN   = 7;
    localparam int LEN_W     = $clog2(MAX_LEN + 1);
    localparam int NUM_CODES = 2;

    typedef logic [MAX_LEN-1:0] pat_t;
    typedef logic [LEN_W-1:0]   len_t;

    typedef enum logic [1:0] {
        PER4 = 2'd0,
        PER5 = 2'd1,
        PER6 = 2'd2,
        PER7 = 2'd3
    } per_sel_e;

    typedef struct packed {
        logic full;
        pat_t bits;
    } win_t;

    function automatic len_t period_of(per_sel_e sel);
        return len_t'(MIN_LEN) + len_t'(sel);
    endfunction

    function automatic pat_t low_mask(len_t n);
        pat_t m;
        for (int i = 0; i < MAX_LEN; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

    // window is a rotation of the code iff it is an N-bit slice of code||code
    function automatic logic is_rotation(pat_t w, pat_t p, len_t n);
        pat_t                     m;
        logic [2*MAX_LEN-1:0]     dbl;
        logic [2*MAX_LEN-1:0]     sh;
        logic                     hit;
        m   = low_mask(n);
        dbl = ({{MAX_LEN{1'b0}}, p & m} << n) | {{MAX_LEN{1'b0}}, p & m};
        hit = 1'b0;
        for (int r = 0; r < MAX_LEN; r++) begin
            sh = dbl >> r;
            if (r < int'(n) && ((pat_t'(sh) & m) == (w & m))) begin
                hit = 1'b1;
            end
        end
        return hit;
    endfunction
endpackage

// File: rtl/ibcode_window.sv
`timescale 1ns/1ps
module ibcode_window
    import ibcode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic t1_mode,
    input  logic bit_vld,
    input  logic bit_in,
    input  len_t n_len,
    output win_t win_o
);
    pat_t hist;
    len_t fill;
    len_t fill_nxt;

    assign fill_nxt   = (fill == len_t'(MAX_LEN)) ? fill : fill + len_t'(1);
    assign win_o.bits = {hist[MAX_LEN-2:0], bit_in};
    assign win_o.full = (fill_nxt >= n_len);

    always_ff @(posedge clk) begin
        if (rst || !t1_mode) begin
            hist <= '0;
            fill <= '0;
        end else if (bit_vld) begin
            hist <= win_o.bits;
            fill <= fill_nxt;
        end
    end

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (t1_mode && !bit_vld) |=> ($stable(hist) && $stable(fill)));

    p_e1_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !t1_mode |=> (hist == '0 && fill == '0));
endmodule

// File: rtl/ibcode_track.sv
`timescale 1ns/1ps
module ibcode_track
    import ibcode_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             t1_mode,
    input  logic             bit_vld,
    input  win_t             win,
    input  pat_t             pat,
    input  len_t             n_len,
    input  logic [CNT_W-1:0] thresh,
    output logic             det_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_nxt;
    logic             hit;
    logic             reach;

    assign hit     = win.full && is_rotation(win.bits, pat, n_len);
    assign cnt_nxt = {1'b0, cnt} + 1'b1;
    assign reach   = (cnt_nxt >= {1'b0, thresh});

    // while absent, count matches; while present, count misses
    always_ff @(posedge clk) begin
        if (rst || !t1_mode) begin
            det_o <= 1'b0;
            cnt   <= '0;
        end else if (bit_vld) begin
            if (hit != det_o) begin
                if (reach) begin
                    det_o <= ~det_o;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt_nxt[CNT_W-1:0];
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    p_e1_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !t1_mode |=> !det_o);

    p_rise_on_hit_r3: assert property (@(posedge clk) disable iff (rst)
        (t1_mode && bit_vld && !det_o && !hit) |=> !det_o);

    p_fall_on_miss_r5: assert property (@(posedge clk) disable iff (rst)
        (t1_mode && bit_vld && det_o && hit) |=> det_o);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (t1_mode && !bit_vld) |=> ($stable(det_o) && $stable(cnt)));
endmodule

// File: rtl/ibcode_irq.sv
`timescale 1ns/1ps
module ibcode_irq
    import ibcode_pkg::*;
#(
    parameter int NUM = NUM_CODES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           t1_mode,
    input  logic [NUM-1:0] status,
    input  logic [NUM-1:0] irq_en,
    input  logic [NUM-1:0] irq_clr,
    output logic [NUM-1:0] irq_stat,
    output logic           irq_req
);
    logic [NUM-1:0] status_q;
    logic [NUM-1:0] rise;

    assign rise    = status & ~status_q;
    assign irq_req = |(irq_stat & irq_en);

    always_ff @(posedge clk) begin
        if (rst || !t1_mode) begin
            status_q <= '0;
            irq_stat <= '0;
        end else begin
            status_q <= status;
            irq_stat <= (irq_stat & ~irq_clr) | rise;
        end
    end

    for (genvar i = 0; i < NUM; i++) begin : g_chk
        p_rise_sets_r7: assert property (@(posedge clk) disable iff (rst)
            (t1_mode && $rose(status[i])) |=> irq_stat[i]);
        p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            (t1_mode && irq_stat[i] && !irq_clr[i]) |=> irq_stat[i]);
    end

    p_req_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq_req);
endmodule

// File: rtl/ibcode_det_top.sv
`timescale 1ns/1ps
module ibcode_det_top
    import ibcode_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             bit_vld,
    input  logic             t1_mode,
    input  logic [1:0]       len_sel,
    input  logic [6:0]       pat_act,
    input  logic [6:0]       pat_deact,
    input  logic [CNT_W-1:0] hit_count,
    input  logic [1:0]       irq_en,
    input  logic [1:0]       irq_clr,
    output logic [1:0]       code_present,
    output logic [1:0]       irq_status,
    output logic             irq_req
);
    len_t n_len;
    win_t win;
    pat_t pats [NUM_CODES];

    assign n_len   = period_of(per_sel_e'(len_sel));
    assign pats[0] = pat_t'(pat_act);
    assign pats[1] = pat_t'(pat_deact);

    ibcode_window u_win (
        .clk     (clk),
        .rst     (rst),
        .t1_mode (t1_mode),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .n_len   (n_len),
        .win_o   (win)
    );

    for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
        ibcode_track #(.CNT_W(CNT_W)) u_trk (
            .clk     (clk),
            .rst     (rst),
            .t1_mode (t1_mode),
            .bit_vld (bit_vld),
            .win     (win),
            .pat     (pats[c]),
            .n_len   (n_len),
            .thresh  (hit_count),
            .det_o   (code_present[c])
        );
    end

    ibcode_irq #(.NUM(NUM_CODES)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .t1_mode  (t1_mode),
        .status   (code_present),
        .irq_en   (irq_en),
        .irq_clr  (irq_clr),
        .irq_stat (irq_status),
        .irq_req  (irq_req)
    );

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (code_present == '0 && irq_status == '0));
endmodule

// File: tb/ibcode_det_top_tb_top.sv
`timescale 1ns/1ps
module ibcode_det_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bit_in;
    logic        bit_vld;
    logic        t1_mode;
    logic [1:0]  len_sel;
    logic [6:0]  pat_act;
    logic [6:0]  pat_deact;
    logic [11:0] hit_count;
    logic [1:0]  irq_en;
    logic [1:0]  irq_clr;
    logic [1:0]  code_present;
    logic [1:0]  irq_status;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit gaps   = 0;

    logic [63:0] m_hist;
    int          m_fill;
    int          m_cnt [2];
    logic        m_det [2];
    logic [1:0]  m_irq;
    logic [1:0]  exp_q [$];

    always #2.5 clk = ~clk;

    ibcode_det_top dut_i (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
        .t1_mode(t1_mode), .len_sel(len_sel), .pat_act(pat_act),
        .pat_deact(pat_deact), .hit_count(hit_count), .irq_en(irq_en),
        .irq_clr(irq_clr), .code_present(code_present),
        .irq_status(irq_status), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_hist = '0;
        m_fill = 0;
        m_irq  = '0;
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 0;
            m_det[c] = 1'b0;
        end
    endtask

    // explicit phase walk: oldest window bit i against code element (i+k) mod N
    function automatic bit m_match(input int c);
        int n;
        logic [6:0] p;
        bit ok;
        n = 4 + int'(len_sel);
        p = c ? pat_deact : pat_act;
        if (m_fill < n) return 0;
        for (int k = 0; k < n; k++) begin
            ok = 1;
            for (int i = 0; i < n; i++) begin
                if (m_hist[n-1-i] !== p[n-1-((i+k)%n)]) ok = 0;
            end
            if (ok) return 1;
        end
        return 0;
    endfunction

    task automatic send_bit(input logic b);
        bit h;
        if (gaps) begin
            repeat (2) begin
                @(negedge clk);
                bit_vld = 1'b0;
                bit_in  = 1'($urandom);
            end
        end
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        if (!t1_mode) begin
            model_reset();
        end else begin
            m_hist = {m_hist[62:0], b};
            if (m_fill < 7) m_fill++;
            for (int c = 0; c < 2; c++) begin
                h = m_match(c);
                if (h != m_det[c]) begin
                    if (m_cnt[c] + 1 >= int'(hit_count)) begin
                        m_det[c] = ~m_det[c];
                        m_cnt[c] = 0;
                        if (m_det[c]) m_irq[c] = 1'b1;
                    end else begin
                        m_cnt[c]++;
                    end
                end else begin
                    m_cnt[c] = 0;
                end
            end
        end
        exp_q.push_back({m_det[1], m_det[0]});
    endtask

    task automatic send_code(input logic [6:0] p, input int n, input int phase, input int count);
        for (int j = 0; j < count; j++) begin
            send_bit(p[n-1-((phase+j)%n)]);
        end
    endtask

    task automatic idle(input int cyc);
        for (int j = 0; j < cyc; j++) begin
            @(negedge clk);
            bit_vld = 1'b0;
        end
    endtask

    task automatic clear_irq(input logic [1:0] mask);
        @(negedge clk);
        bit_vld = 1'b0;
        irq_clr = mask;
        @(negedge clk);
        irq_clr = 2'b00;
        m_irq   = m_irq & ~mask;
    endtask

    task automatic check_irq(input string req);
        idle(2);
        check({req, " irq_status"}, 32'(irq_status), 32'(m_irq));
        check({req, " irq_req"}, 32'(irq_req), 32'(|(m_irq & irq_en)));
    endtask

    // scoreboard monitor: one expected presence pair per sampled valid bit
    always @(posedge clk) begin
        if (bit_vld === 1'b1 && rst === 1'b0) begin
            #1;
            if (exp_q.size() == 0) begin
                check("R3 scoreboard underflow", 32'd1, 32'd0);
            end else begin
                check("R3/R5/R6 code_present", 32'(code_present), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bit_in = 1'b0; bit_vld = 1'b0; t1_mode = 1'b1;
        len_sel = 2'd1; pat_act = 7'b1100001; pat_deact = 7'b1000111;
        hit_count = 12'd20; irq_en = 2'b11; irq_clr = 2'b00;
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 code_present", 32'(code_present), 32'd0);
        check("R1 irq_status", 32'(irq_status), 32'd0);
        check("R1 irq_req", 32'(irq_req), 32'd0);

        // R2 R3: 5-bit activate code, upper pattern bits junk, start at phase 2
        send_code(7'b0000001, 5, 2, 30);
        check("R3 activate present", 32'(code_present[0]), 32'd1);
        check_irq("R7 set on rise");

        // R5: zeros clear presence; R7 sticky status survives
        for (int j = 0; j < 25; j++) send_bit(1'b0);
        check("R5 activate cleared", 32'(code_present[0]), 32'd0);
        check_irq("R7 sticky");
        clear_irq(2'b01);
        check_irq("R7 w1c");

        // R4: 15 matches, one wrong bit, 14 more: never reaches 20
        send_code(7'b0000001, 5, 0, 15);
        send_bit(1'b1);
        send_code(7'b0000001, 5, 1, 14);
        check("R4 interrupted run", 32'(code_present[0]), 32'd0);
        for (int j = 0; j < 10; j++) send_bit(1'b0);

        // R2 R9 R8: 3-bit code as 6-bit period, qualifier gaps, deactivate masked
        idle(1);
        len_sel = 2'd2; pat_deact = 7'b0110110; irq_en = 2'b01;
        gaps = 1;
        send_code(7'b0000110, 3, 1, 30);
        gaps = 0;
        check("R9 R2 deactivate present", 32'(code_present[1]), 32'd1);
        check_irq("R8 masked");
        irq_en = 2'b11;
        #1;
        check("R8 enable opens request", 32'(irq_req), 32'd1);
        clear_irq(2'b11);
        for (int j = 0; j < 25; j++) send_bit(1'b1);
        check_irq("R8 after clear");

        // R6: period 4, codes are rotations of each other, both present together
        idle(1);
        len_sel = 2'd0; pat_act = 7'b1111010; pat_deact = 7'b0110101;
        send_code(7'b0001010, 4, 3, 30);
        check("R6 both present", 32'(code_present), 32'd3);
        check_irq("R6 both irq");
        clear_irq(2'b11);

        // R2: period 7, all pattern bits used
        idle(1);
        len_sel = 2'd3; pat_act = 7'b1110010; pat_deact = 7'b0000001;
        send_code(7'b1110010, 7, 3, 40);
        check("R2 period 7 present", 32'(code_present[0]), 32'd1);

        // R10: E1 mode clears and ignores
        idle(1);
        t1_mode = 1'b0;
        model_reset();
        idle(2);
        check("R10 status cleared", 32'(code_present), 32'd0);
        send_code(7'b1110010, 7, 0, 40);
        check_irq("R10 quiet");
        check("R10 still absent", 32'(code_present), 32'd0);

        // back to T1: needs a fresh full run
        idle(1);
        t1_mode = 1'b1;
        send_code(7'b1110010, 7, 5, 30);
        check("R3 redetect after T1 entry", 32'(code_present[0]), 32'd1);
        check_irq("R7 rise after T1 entry");

        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule